// File: doc/BRIEF.md
# Indirect Sub-Addressed Control Register Bank

This block is the host-side control register file of a network controller. A CPU reaches it through eight direct 8-bit locations. Direct location 7 is a window onto several internal registers. A three-bit selector decides which of those registers the window reaches. The low two selector bits are shared storage with the configuration register. The third selector bit clears itself whenever the configuration register is written.

The block also holds a pair of address-pointer registers. A write to the low pointer can raise a DMA request. The request stays high until the DMA engine acknowledges it. When wide (16-bit) access is enabled, the lowest pointer bit becomes a byte-swap control. The block has two resets. A hardware reset initialises everything. A synchronous soft reset clears only the pointer state and the DMA request.

Top module: `ctl_regbank`

## Requirements
- R1: After hardware reset, the configuration register (direct address 0) reads 8'h18, the window registers read 8'h00, both pointers read 8'h00, the selector is 3'b000 and `dma_req` is low.
- R2: Selector bits 1:0 are the same storage as configuration bits 1:0. A write to address 0 or to address 1 changes what both addresses read back in those bits.
- R3: Address 1 reads {5'b0, sel2, cfg[1:0]}. Writing address 1 loads sel2 from write-data bit 2, and write-data bits 7:3 have no effect. Any write to address 0 clears sel2 to 0.
- R4: At address 7, selector code 0 reaches setup 1 and code 1 reaches the node-id register. Code 4 reaches setup 2, code 5 reaches bus control and code 6 reaches the DMA count. Each is a full 8-bit read/write register.
- R5: Selector codes 2, 3 and 7 read 8'h00 at address 7, and writes to them change no register. Direct addresses 4, 5 and 6 read 8'h00, and writes to them change no register.
- R6: A write to the low pointer (address 3) while bit 3 of the high pointer (address 2) is set raises `dma_req` on the next clock. Only this write raises it. `dma_req` falls on the clock after `dma_ack` is sampled high, unless a new trigger write occurs in that cycle. A write to address 2 with bit 3 clear also drops it.
- R7: `wide_mode` equals configuration bit 2. `byte_swap` equals low-pointer bit 0 while `wide_mode` is set, and is 0 otherwise.
- R8: While `soft_rst` is high, both pointers and `dma_req` are cleared on the clock. The configuration register, the selector and all window registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| addr | input | 3 | CPU direct address |
| wdata | input | 8 | CPU write data |
| wr | input | 1 | CPU write strobe, one write per clock |
| rdata | output | 8 | CPU read data for `addr`, combinational |
| dma_ack | input | 1 | Acknowledge from the DMA engine |
| dma_req | output | 1 | DMA request |
| byte_swap | output | 1 | Swap upper and lower data bytes |
| wide_mode | output | 1 | 16-bit access enabled |

## Verification
The hardest state to reach from the ports is an extended window register read back through the alias. Getting there takes a selector write that sets bit 2, then an intervening configuration write that silently clears it, while the low bits must stay consistent through both paths. Random writes over all eight addresses, with data biased toward selector values, walk through these sequences many times. After each write a bench model predicts every address's read value. Directed steps cover a DMA trigger racing an acknowledge, and soft reset with a populated window.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter logic [7:0] CFG_RST = 8'h18,
  parameter int WIDE_BIT  = 2,
  parameter int DMAEN_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  output logic [DW-1:0] rdata,
  input  logic          dma_ack,
  output logic          dma_req,
  output logic          byte_swap,
  output logic          wide_mode
);
  localparam logic [AW-1:0] A_CFG = 0, A_SUB = 1, A_PHI = 2, A_PLO = 3, A_WIN = 7;

  logic [DW-1:0] cfg_q, setup1_q, node_q, setup2_q, bus_q, cnt_q, phi_q, plo_q;
  logic          sel2_q, req_q;
  logic [2:0]    sel;

  assign sel = {sel2_q, cfg_q[1:0]};
  wire win_wr = wr && addr == A_WIN;
  wire trig   = wr && addr == A_PLO && phi_q[DMAEN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST; sel2_q <= 1'b0;
      setup1_q <= '0; node_q <= '0; setup2_q <= '0; bus_q <= '0; cnt_q <= '0;
    end else if (wr) begin
      case (addr)
        A_CFG: begin cfg_q <= wdata; sel2_q <= 1'b0; end
        A_SUB: begin cfg_q[1:0] <= wdata[1:0]; sel2_q <= wdata[2]; end
        default: ;
      endcase
      if (win_wr)
        case (sel)
          3'd0: setup1_q <= wdata;
          3'd1: node_q   <= wdata;
          3'd4: setup2_q <= wdata;
          3'd5: bus_q    <= wdata;
          3'd6: cnt_q    <= wdata;
          default: ;
        endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q <= '0; plo_q <= '0; req_q <= 1'b0;
    end else if (soft_rst) begin
      phi_q <= '0; plo_q <= '0; req_q <= 1'b0;
    end else begin
      if (wr && addr == A_PHI) phi_q <= wdata;
      if (wr && addr == A_PLO) plo_q <= wdata;
      if (trig) req_q <= 1'b1;
      else if (wr && addr == A_PHI && !wdata[DMAEN_BIT]) req_q <= 1'b0;
      else if (dma_ack) req_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG: rdata = cfg_q;
      A_SUB: rdata = {{(DW-3){1'b0}}, sel};
      A_PHI: rdata = phi_q;
      A_PLO: rdata = plo_q;
      A_WIN:
        case (sel)
          3'd0: rdata = setup1_q;
          3'd1: rdata = node_q;
          3'd4: rdata = setup2_q;
          3'd5: rdata = bus_q;
          3'd6: rdata = cnt_q;
          default: rdata = '0;
        endcase
      default: rdata = '0;
    endcase
  end

  assign dma_req   = req_q;
  assign wide_mode = cfg_q[WIDE_BIT];
  assign byte_swap = wide_mode & plo_q[0];

  AST_SEL2_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CFG) |=> !sel2_q); // R3
  AST_ALIAS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_SUB) |=> cfg_q[1:0] == $past(wdata[1:0])); // R2
  AST_REQ_ONLY_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(wr && addr == A_PLO && phi_q[DMAEN_BIT])); // R6
  AST_REQ_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !trig && !soft_rst) |=> !dma_req); // R6
  AST_SOFT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr) |=> $stable(cfg_q) && $stable(setup1_q)); // R8
  AST_SWAP_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_swap |-> wide_mode); // R7
endmodule

// File: tb/sim_ctl_regbank.sv
module sim_ctl_regbank;
  localparam int TCLK = 10;
  logic clk = 0, rst_n = 0, soft_rst = 0, wr = 0, dma_ack = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic dma_req, byte_swap, wide_mode;
  int checks = 0, errors = 0;

  ctl_regbank u0 (.clk, .rst_n, .soft_rst, .addr, .wdata, .wr, .rdata,
                  .dma_ack, .dma_req, .byte_swap, .wide_mode);

  always #(TCLK/2) clk = ~clk;

  logic [7:0] m_cfg, m_s1, m_node, m_s2, m_bus, m_cnt, m_phi, m_plo;
  logic m_sel2, m_req;

  task automatic model_reset();
    m_cfg = 8'h18; m_s1 = 0; m_node = 0; m_s2 = 0; m_bus = 0; m_cnt = 0;
    m_phi = 0; m_plo = 0; m_sel2 = 0; m_req = 0;
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic [2:0] s = {m_sel2, m_cfg[1:0]};
    case (a)
      3'd0: return m_cfg;
      3'd1: return {5'b0, s};
      3'd2: return m_phi;
      3'd3: return m_plo;
      3'd7: case (s)
              3'd0: return m_s1; 3'd1: return m_node; 3'd4: return m_s2;
              3'd5: return m_bus; 3'd6: return m_cnt; default: return 8'h00;
            endcase
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk(tag, rdata, exp_read(3'(a)));
    end
    chk({tag, " R6 dma_req"}, {7'b0, dma_req}, {7'b0, m_req});
    chk({tag, " R7 wide_mode"}, {7'b0, wide_mode}, {7'b0, m_cfg[2]});
    chk({tag, " R7 byte_swap"}, {7'b0, byte_swap}, {7'b0, m_cfg[2] & m_plo[0]});
  endtask

  // one clock: drive at negedge, model updates at posedge, return at next negedge
  task automatic cycle(input logic w, input logic [2:0] a, input logic [7:0] d,
                       input logic ack, input logic srst);
    logic [2:0] s = {m_sel2, m_cfg[1:0]};
    logic trig;
    wr = w; addr = a; wdata = d; dma_ack = ack; soft_rst = srst;
    @(posedge clk);
    trig = w && a == 3 && m_phi[3];
    if (w) begin
      if (a == 0) begin m_cfg = d; m_sel2 = 0; end
      if (a == 1) begin m_cfg[1:0] = d[1:0]; m_sel2 = d[2]; end
      if (a == 7) case (s)
        3'd0: m_s1 = d; 3'd1: m_node = d; 3'd4: m_s2 = d;
        3'd5: m_bus = d; 3'd6: m_cnt = d; default: ;
      endcase
    end
    if (srst) begin m_phi = 0; m_plo = 0; m_req = 0; end
    else begin
      if (trig) m_req = 1;
      else if (w && a == 2 && !d[3]) m_req = 0;
      else if (ack) m_req = 0;
      if (w && a == 2) m_phi = d;
      if (w && a == 3) m_plo = d;
    end
    @(negedge clk);
    wr = 0; dma_ack = 0; soft_rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R2/R3: alias and self-clear of sel2
    cycle(1, 1, 8'hFD, 0, 0);           // sel=5, upper bits ignored
    check_all("R2 R3 sub write");
    cycle(1, 7, 8'hA5, 0, 0);           // bus control
    check_all("R4 bus ctl");
    cycle(1, 0, 8'h06, 0, 0);           // cfg write clears sel2, wide on
    check_all("R3 cfg clears sel2");
    cycle(1, 7, 8'h3C, 0, 0);           // node id via code 2? cfg[1:0]=2 -> unused
    check_all("R5 unused code write");
    cycle(1, 1, 8'h07, 0, 0);
    cycle(1, 7, 8'h99, 0, 0);           // unused code 7
    check_all("R5 code7");
    cycle(1, 5, 8'hFF, 0, 0);
    check_all("R5 unused direct");

    // R6: trigger, hold, ack drop, race
    cycle(1, 3, 8'h11, 0, 0);           // no enable
    check_all("R6 no enable");
    cycle(1, 2, 8'h08, 0, 0);
    cycle(1, 3, 8'h21, 0, 0);
    check_all("R6 trigger R7 swap");
    cycle(0, 0, 0, 0, 0);
    check_all("R6 hold");
    cycle(1, 3, 8'h20, 1, 0);           // trigger wins over ack
    check_all("R6 race");
    cycle(0, 0, 0, 1, 0);
    check_all("R6 ack drop");
    cycle(1, 3, 8'h01, 0, 0);
    cycle(1, 1, 8'h04, 0, 0);
    cycle(1, 7, 8'h5A, 0, 0);           // setup2
    cycle(0, 0, 0, 0, 1);               // soft reset
    check_all("R8 soft reset");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if (a == 1 && $urandom_range(0, 1) == 1) d = {5'b0, 3'($urandom)};
      cycle($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 5) == 0,
            $urandom_range(0, 40) == 0);
      check_all("R4 random");
    end

    rst_n = 0; #1; model_reset(); @(negedge clk); rst_n = 1; @(negedge clk);
    check_all("R1 second reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule